// File: doc/BRIEF.md
# Tamper Detection and Backup Erase Controller

This block watches a set of external tamper pins and a set of internal event lines. When an enabled source fires, the block records a sticky per-source flag and can raise an interrupt. It also wipes a small register file that survives system reset. Each external pin is set up with its own options: a detection style, which is a raw edge or a level that must hold across prescaler ticks; an optional timestamp mode, which adds latency; a polarity; a mask; and a bit that keeps the wipe from happening. A masked pin keeps no flag. It sends a one-cycle pulse to an external low-power timer and then stays deaf for a short holdoff.

Software reaches the block through a plain single-cycle register port. Writes complete in the clock they are presented, and reads are combinational from the address. There is no stream interface, so there is no valid/ready and no back-pressure. Timing is paced by two single-cycle enables that the block receives from outside: a prescaler tick and a slower RTC-rate tick. A top-level write-unlock input gates every write. Two resets are used. `rst_n_i` is the system reset and leaves the backup file alone. `pd_rst_n_i` is the power-domain reset and clears the backup file.

Top module: `tamp_ctrl`

Register offsets (word addresses):
- CTRL at 0: pin enables in bits [N-1:0], internal enables in bits [16+M-1:16].
- LVL at 1: level mode per pin.
- TS at 2: timestamp mode per pin.
- POL at 3: 1 makes the pin active-low.
- MASK at 4.
- NOER at 5: pin no-erase bits, plus the internal no-erase bit at 31.
- IE at 6: pins in low bits, internal sources at 16 and up.
- STAT at 7: flags, read-only, same layout as IE.
- CLR at 8: write 1 to clear a flag.
- CMD at 9: bit 0 requests a software erase.
- Backup word k at 16+k.

## Requirements
- R1: While `wr_unlock_i` is 0, every register write is ignored, the backup words and the CMD erase included.
- R2: The backup words keep their values through `rst_n_i`. Only `pd_rst_n_i`, a detection erase or a software erase clears them. `rst_n_i` clears all configuration and flags.
- R3: When a pin's detection completes with its MASK and NOER bits both 0, all backup words clear and `erase_o` pulses. The pulse appears in the same cycle as the flag. An internal event erases unless NOER bit 31 is 1.
- R4: A source whose enable bit in CTRL is 0 is never detected.
- R5: Flags are sticky until a 1 is written to the matching CLR bit. A set in the same cycle as a clear wins.
- R6: With LVL=0 and TS=0, the flag is visible one clock after the first cycle in which the pin's active level follows an inactive sample.
- R7: With TS=1 in edge mode, the flag becomes visible after the third prescaler tick that follows the detected edge.
- R8: With LVL=1, the pin must sit at its active level (polarity from POL) on two consecutive prescaler ticks. The flag follows three further ticks, which makes five ticks in total from a pin that was already active.
- R9: Further events on a pin are ignored while its latency runs and while its flag is set.
- R10: A masked pin sets no flag. It drives a one-cycle pulse on its `lptim_trig_o` bit and then ignores events until three RTC ticks have passed.
- R11: `irq_o` is 1 whenever some source has both its IE bit and its flag set.
- R12: A write to IE that would set the bit of a pin whose MASK bit is 1 leaves that bit unchanged. The other bits in the same write take effect.
- R13: Writing CMD bit 0 clears all backup words and pulses `erase_o` in the next cycle, with or without any tamper event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | System reset, active low; backup words kept |
| pd_rst_n_i | input | 1 | Power-domain reset, active low; clears backup words |
| wr_unlock_i | input | 1 | 1 allows register writes |
| reg_we_i | input | 1 | Write strobe |
| reg_addr_i | input | AW | Word address |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Combinational read data |
| pre_tick_i | input | 1 | Prescaler-rate enable |
| rtc_tick_i | input | 1 | RTC-rate enable |
| tamp_pin_i | input | N_PIN | Tamper pins, synchronous to clk_i |
| int_evt_i | input | N_INT | Internal tamper event pulses |
| irq_o | output | 1 | Interrupt |
| erase_o | output | 1 | One-cycle erase pulse |
| lptim_trig_o | output | N_PIN | Per-pin trigger pulse for masked pins |

## Verification
Every result is due after a known number of clock edges or ticks:
- In edge mode, the flag and `erase_o` are due on the clock edge that sees the edge.
- In timestamp mode, they are due on the third prescaler tick after that edge.
- In level mode, they are due on the fifth tick.
- A masked trigger is due one edge after detection, and the next pin edge is not accepted until three RTC ticks have passed.

The bench drives each tick as an isolated one-clock pulse and reads outputs at the falling edge. It checks the tick just before each due point and the tick at the due point, so a latency that is off by one cycle is reported. Each blanked or ignored event is confirmed through a port afterwards, by reading the flags, the trigger pins or the backup words.

// File: rtl/tamp_pkg.sv
package tamp_pkg;
  typedef enum logic [1:0] {CH_IDLE, CH_LAT, CH_HOLD} ch_state_e;

  localparam int LAT_TICKS    = 3;
  localparam int HOLD_TICKS   = 3;
  localparam int FILT_SAMPLES = 2;
  localparam int CNT_W  = $clog2((LAT_TICKS > HOLD_TICKS ? LAT_TICKS : HOLD_TICKS) + 1);
  localparam int FILT_W = $clog2(FILT_SAMPLES + 1);

  localparam int A_CTRL = 0;
  localparam int A_LVL  = 1;
  localparam int A_TS   = 2;
  localparam int A_POL  = 3;
  localparam int A_MASK = 4;
  localparam int A_NOER = 5;
  localparam int A_IE   = 6;
  localparam int A_STAT = 7;
  localparam int A_CLR  = 8;
  localparam int A_CMD  = 9;
  localparam int BKP_BASE = 16;

  localparam int INT_LSB     = 16;
  localparam int INT_NOER_BIT = 31;
endpackage

// File: rtl/tamp_chan.sv
module tamp_chan
  import tamp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic pin_i,
  input  logic pre_tick_i,
  input  logic rtc_tick_i,
  input  logic en_i,
  input  logic lvl_i,
  input  logic ts_i,
  input  logic inv_i,
  input  logic mask_i,
  input  logic flag_i,
  output logic fire_o
);
  ch_state_e state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [FILT_W-1:0] fcnt_q, fcnt_d;
  logic act, prev_q, blanked, raw_det, det, immediate;

  assign act       = pin_i ^ inv_i;
  assign blanked   = (state_q != CH_IDLE) || flag_i;
  assign immediate = !lvl_i && !ts_i;
  assign raw_det   = lvl_i ? (pre_tick_i && act && (fcnt_q == FILT_W'(FILT_SAMPLES - 1)))
                           : (act && !prev_q);
  assign det       = en_i && !blanked && raw_det;

  // level filter: consecutive active samples on prescaler ticks
  always_comb begin
    fcnt_d = fcnt_q;
    if (!en_i || !lvl_i || blanked) begin
      fcnt_d = '0;
    end else if (pre_tick_i) begin
      if (!act)                                          fcnt_d = '0;
      else if (fcnt_q != FILT_W'(FILT_SAMPLES - 1))      fcnt_d = fcnt_q + 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fire_o  = 1'b0;
    unique case (state_q)
      CH_IDLE: begin
        if (det) begin
          cnt_d = '0;
          if (immediate) begin
            fire_o = 1'b1;
            if (mask_i) state_d = CH_HOLD;
          end else begin
            state_d = CH_LAT;
          end
        end
      end
      CH_LAT: begin
        if (!en_i) begin
          state_d = CH_IDLE;
          cnt_d   = '0;
        end else if (pre_tick_i) begin
          if (cnt_q == CNT_W'(LAT_TICKS - 1)) begin
            fire_o  = 1'b1;
            cnt_d   = '0;
            state_d = mask_i ? CH_HOLD : CH_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      CH_HOLD: begin
        if (rtc_tick_i) begin
          if (cnt_q == CNT_W'(HOLD_TICKS - 1)) begin
            cnt_d   = '0;
            state_d = CH_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = CH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= CH_IDLE;
      cnt_q   <= '0;
      fcnt_q  <= '0;
      prev_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      fcnt_q  <= fcnt_d;
      prev_q  <= act;
    end
  end

  a_r9_no_fire_while_flagged: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    flag_i |-> !fire_o);
  a_r10_hold_is_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (state_q == CH_HOLD) |-> !fire_o);
  a_r7_latency_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (state_q == CH_LAT && !pre_tick_i) |-> !fire_o);
endmodule

// File: rtl/tamp_regs.sv
module tamp_regs
  import tamp_pkg::*;
#(
  parameter int N_PIN = 3,
  parameter int N_INT = 2,
  parameter int DW    = 32,
  parameter int AW    = 6
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             unlock_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [N_PIN-1:0] fire_i,
  input  logic [N_INT-1:0] int_evt_i,
  output logic [N_PIN-1:0] en_o,
  output logic [N_PIN-1:0] lvl_o,
  output logic [N_PIN-1:0] ts_o,
  output logic [N_PIN-1:0] inv_o,
  output logic [N_PIN-1:0] mask_o,
  output logic [N_PIN-1:0] flag_o,
  output logic             irq_o,
  output logic             erase_req_o,
  output logic             erase_o,
  output logic [DW-1:0]    rdata_o
);
  logic [N_PIN-1:0] en_q, lvl_q, ts_q, inv_q, mask_q, noer_q, ie_q, flag_q, clr_pin;
  logic [N_INT-1:0] int_en_q, int_ie_q, int_flag_q, int_fire, clr_int;
  logic             int_noer_q, erase_q, wr, sw_erase, pin_erase, int_erase;

  assign wr = we_i && unlock_i;

  function automatic logic hit(input logic [AW-1:0] a, input int off);
    return a == AW'(off);
  endfunction

  assign clr_pin  = (wr && hit(addr_i, A_CLR)) ? wdata_i[N_PIN-1:0] : '0;
  assign clr_int  = (wr && hit(addr_i, A_CLR)) ? wdata_i[INT_LSB +: N_INT] : '0;
  assign sw_erase = wr && hit(addr_i, A_CMD) && wdata_i[0];

  assign int_fire  = int_evt_i & int_en_q & ~int_flag_q;
  assign pin_erase = |(fire_i & ~mask_q & ~noer_q);
  assign int_erase = (|int_fire) && !int_noer_q;
  assign erase_req_o = sw_erase || pin_erase || int_erase;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      en_q <= '0; lvl_q <= '0; ts_q <= '0; inv_q <= '0;
      mask_q <= '0; noer_q <= '0; ie_q <= '0; flag_q <= '0;
      int_en_q <= '0; int_ie_q <= '0; int_flag_q <= '0;
      int_noer_q <= 1'b0; erase_q <= 1'b0;
    end else begin
      erase_q    <= erase_req_o;
      flag_q     <= (flag_q & ~clr_pin) | (fire_i & ~mask_q);
      int_flag_q <= (int_flag_q & ~clr_int) | int_fire;
      if (wr) begin
        if (hit(addr_i, A_CTRL)) begin
          en_q     <= wdata_i[N_PIN-1:0];
          int_en_q <= wdata_i[INT_LSB +: N_INT];
        end
        if (hit(addr_i, A_LVL))  lvl_q  <= wdata_i[N_PIN-1:0];
        if (hit(addr_i, A_TS))   ts_q   <= wdata_i[N_PIN-1:0];
        if (hit(addr_i, A_POL))  inv_q  <= wdata_i[N_PIN-1:0];
        if (hit(addr_i, A_MASK)) mask_q <= wdata_i[N_PIN-1:0];
        if (hit(addr_i, A_NOER)) begin
          noer_q     <= wdata_i[N_PIN-1:0];
          int_noer_q <= wdata_i[INT_NOER_BIT];
        end
        if (hit(addr_i, A_IE)) begin
          // masked pins keep their old interrupt enable
          ie_q     <= (wdata_i[N_PIN-1:0] & ~mask_q) | (ie_q & mask_q);
          int_ie_q <= wdata_i[INT_LSB +: N_INT];
        end
      end
    end
  end

  assign irq_o   = (|(ie_q & flag_q)) || (|(int_ie_q & int_flag_q));
  assign erase_o = erase_q;
  assign en_o    = en_q;
  assign lvl_o   = lvl_q;
  assign ts_o    = ts_q;
  assign inv_o   = inv_q;
  assign mask_o  = mask_q;
  assign flag_o  = flag_q;

  always_comb begin
    rdata_o = '0;
    if (hit(addr_i, A_CTRL)) begin
      rdata_o[N_PIN-1:0]       = en_q;
      rdata_o[INT_LSB +: N_INT] = int_en_q;
    end
    if (hit(addr_i, A_LVL))  rdata_o[N_PIN-1:0] = lvl_q;
    if (hit(addr_i, A_TS))   rdata_o[N_PIN-1:0] = ts_q;
    if (hit(addr_i, A_POL))  rdata_o[N_PIN-1:0] = inv_q;
    if (hit(addr_i, A_MASK)) rdata_o[N_PIN-1:0] = mask_q;
    if (hit(addr_i, A_NOER)) begin
      rdata_o[N_PIN-1:0]   = noer_q;
      rdata_o[INT_NOER_BIT] = int_noer_q;
    end
    if (hit(addr_i, A_IE)) begin
      rdata_o[N_PIN-1:0]       = ie_q;
      rdata_o[INT_LSB +: N_INT] = int_ie_q;
    end
    if (hit(addr_i, A_STAT)) begin
      rdata_o[N_PIN-1:0]       = flag_q;
      rdata_o[INT_LSB +: N_INT] = int_flag_q;
    end
  end

  a_r1_config_locked: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !unlock_i |=> ($stable(en_q) && $stable(mask_q) && $stable(ie_q) && $stable(noer_q)));
  a_r12_ie_rejected: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (we_i && unlock_i && hit(addr_i, A_IE)) |=> ((ie_q & ~$past(ie_q) & $past(mask_q)) == '0));
  a_r3_erase_follows_fire: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (|(fire_i & ~mask_q & ~noer_q)) |=> erase_o);
endmodule

// File: rtl/tamp_bkp.sv
module tamp_bkp #(
  parameter int NB = 8,
  parameter int DW = 32,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk_i,
  input  logic          pd_rst_n_i,
  input  logic          unlock_i,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          erase_i,
  output logic [DW-1:0] rdata_o
);
  logic [NB-1:0][DW-1:0] mem_q;

  always_ff @(posedge clk_i or negedge pd_rst_n_i) begin
    if (!pd_rst_n_i) begin
      mem_q <= '0;
    end else if (erase_i) begin
      mem_q <= '0;
    end else if (we_i && unlock_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];

  a_r1_bkp_locked: assert property (@(posedge clk_i) disable iff (!pd_rst_n_i)
    (!unlock_i && !erase_i) |=> $stable(mem_q));
endmodule

// File: rtl/tamp_ctrl.sv
module tamp_ctrl
  import tamp_pkg::*;
#(
  parameter int N_PIN = 3,
  parameter int N_INT = 2,
  parameter int N_BKP = 8,
  parameter int DW    = 32,
  parameter int AW    = 6
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             pd_rst_n_i,
  input  logic             wr_unlock_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             pre_tick_i,
  input  logic             rtc_tick_i,
  input  logic [N_PIN-1:0] tamp_pin_i,
  input  logic [N_INT-1:0] int_evt_i,
  output logic             irq_o,
  output logic             erase_o,
  output logic [N_PIN-1:0] lptim_trig_o
);
  localparam int IW = (N_BKP > 1) ? $clog2(N_BKP) : 1;

  logic [N_PIN-1:0] en, lvl, ts, inv, mask, flag, fire, trig_q;
  logic             erase_req, in_bkp;
  logic [DW-1:0]    regs_rd, bkp_rd;
  logic [IW-1:0]    bkp_idx;

  assign in_bkp  = (reg_addr_i >= AW'(BKP_BASE)) && (reg_addr_i < AW'(BKP_BASE + N_BKP));
  assign bkp_idx = IW'(reg_addr_i - AW'(BKP_BASE));

  tamp_regs #(.N_PIN(N_PIN), .N_INT(N_INT), .DW(DW), .AW(AW)) regs_i (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .unlock_i(wr_unlock_i),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .fire_i(fire), .int_evt_i(int_evt_i),
    .en_o(en), .lvl_o(lvl), .ts_o(ts), .inv_o(inv), .mask_o(mask), .flag_o(flag),
    .irq_o(irq_o), .erase_req_o(erase_req), .erase_o(erase_o), .rdata_o(regs_rd)
  );

  for (genvar g = 0; g < N_PIN; g++) begin : g_chan
    tamp_chan chan_i (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .pin_i(tamp_pin_i[g]),
      .pre_tick_i(pre_tick_i), .rtc_tick_i(rtc_tick_i),
      .en_i(en[g]), .lvl_i(lvl[g]), .ts_i(ts[g]), .inv_i(inv[g]),
      .mask_i(mask[g]), .flag_i(flag[g]), .fire_o(fire[g])
    );
  end

  tamp_bkp #(.NB(N_BKP), .DW(DW)) bkp_i (
    .clk_i(clk_i), .pd_rst_n_i(pd_rst_n_i), .unlock_i(wr_unlock_i),
    .we_i(reg_we_i && in_bkp), .idx_i(bkp_idx), .wdata_i(reg_wdata_i),
    .erase_i(erase_req), .rdata_o(bkp_rd)
  );

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) trig_q <= '0;
    else          trig_q <= fire & mask;
  end

  assign lptim_trig_o = trig_q;
  assign reg_rdata_o  = in_bkp ? bkp_rd : regs_rd;

  a_r10_trig_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (trig_q & $past(trig_q)) == '0);
  a_r10_trig_not_flagged: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (trig_q & $past(fire) & ~$past(mask)) == '0);
endmodule

// File: tb/tamp_ctrl_tb_top.sv
module tamp_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, pd_rst_n, unlock, we, pre_tick, rtc_tick, irq, erase;
  logic [5:0]  addr;
  logic [31:0] wdata, rdata, v;
  logic [2:0]  pin, trig;
  logic [1:0]  ievt;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  tamp_ctrl dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .pd_rst_n_i(pd_rst_n), .wr_unlock_i(unlock),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pre_tick_i(pre_tick), .rtc_tick_i(rtc_tick), .tamp_pin_i(pin), .int_evt_i(ievt),
    .irq_o(irq), .erase_o(erase), .lptim_trig_o(trig)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    step();
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic tick_pre();
    pre_tick = 1'b1; step(); pre_tick = 1'b0;
  endtask

  task automatic tick_rtc();
    rtc_tick = 1'b1; step(); rtc_tick = 1'b0;
  endtask

  task automatic fill_bkp();
    for (int k = 0; k < 8; k++) wr(6'(16 + k), 32'hA0 + k);
  endtask

  task automatic t_reset();
    rd(7, v);  chk("R2 reset flags", v, 0);
    rd(0, v);  chk("R2 reset ctrl", v, 0);
    chk("R11 reset irq", irq, 0);
    chk("R3 reset erase", erase, 0);
    chk("R10 reset trig", trig, 0);
  endtask

  task automatic t_lock();
    unlock = 1'b0;
    wr(0, 32'h7);
    wr(16, 32'h55);
    rd(0, v);  chk("R1 ctrl locked", v, 0);
    rd(16, v); chk("R1 bkp locked", v, 0);
    unlock = 1'b1;
    fill_bkp();
    rd(23, v); chk("R1 bkp write open", v, 32'hA7);
    unlock = 1'b0;
    wr(9, 1);
    rd(16, v); chk("R1 locked sw erase", v, 32'hA0);
    unlock = 1'b1;
  endtask

  task automatic t_sysreset();
    wr(0, 1);
    rst_n = 1'b0; step(); rst_n = 1'b1; step();
    rd(16, v); chk("R2 bkp kept on sys reset", v, 32'hA0);
    rd(0, v);  chk("R2 ctrl cleared", v, 0);
  endtask

  task automatic t_edge();
    wr(5, 32'h7);
    pin[1] = 1'b1; step(); pin[1] = 1'b0; step(); pin[1] = 1'b1; step();
    rd(7, v);  chk("R4 disabled pin no flag", v, 0);
    wr(0, 1);
    pin[0] = 1'b1; step();
    rd(7, v);  chk("R6 edge flag next clock", v, 1);
    chk("R3 noerase suppresses erase", erase, 0);
    pin[0] = 1'b0; step(); pin[0] = 1'b1; step();
    wr(8, 1);
    rd(7, v);  chk("R9 edge while flagged ignored", v, 0);
    rd(16, v); chk("R3 noerase keeps bkp", v, 32'hA0);
  endtask

  task automatic t_ts();
    wr(2, 32'h2);
    wr(0, 32'h3);
    pin[1] = 1'b0; step(); pin[1] = 1'b1; step();
    tick_pre(); tick_pre();
    rd(7, v);  chk("R7 ts no flag after 2 ticks", v, 0);
    tick_pre();
    rd(7, v);  chk("R7 ts flag after 3 ticks", v, 2);
  endtask

  task automatic t_level();
    wr(1, 32'h4);
    wr(3, 32'h4);
    wr(0, 32'h7);
    pin[2] = 1'b0;
    for (int k = 0; k < 4; k++) tick_pre();
    rd(7, v);  chk("R8 level no flag after 4 ticks", v, 2);
    tick_pre();
    rd(7, v);  chk("R8 level flag after 5 ticks", v, 6);
  endtask

  task automatic t_irq();
    wr(6, 32'h2);
    chk("R11 irq with ie and flag", irq, 1);
    wr(8, 32'h2);
    chk("R11 irq after clear", irq, 0);
    rd(7, v);  chk("R5 clear one flag", v, 4);
  endtask

  task automatic t_mask();
    wr(0, 1);
    pin[2] = 1'b1;
    wr(8, 32'h7);
    wr(4, 1);
    wr(6, 32'h3);
    rd(6, v);  chk("R12 ie write rejected on masked pin", v, 2);
    wr(5, 0);
    pin[0] = 1'b0; step(); pin[0] = 1'b1; step();
    chk("R10 masked trigger pulse", trig, 1);
    chk("R3 mask suppresses erase", erase, 0);
    rd(7, v);  chk("R10 masked no flag", v, 0);
    step();
    chk("R10 trigger single cycle", trig, 0);
    tick_rtc(); tick_rtc();
    pin[0] = 1'b0; step(); pin[0] = 1'b1; @(posedge clk); @(negedge clk);
    chk("R10 holdoff blanks edge", trig, 0);
    step();
    chk("R10 holdoff blanks edge later", trig, 0);
    tick_rtc();
    pin[0] = 1'b0; step(); pin[0] = 1'b1; step();
    chk("R10 edge after holdoff", trig, 1);
    rd(16, v); chk("R3 mask keeps bkp", v, 32'hA0);
    tick_rtc(); tick_rtc(); tick_rtc();
  endtask

  task automatic t_erase();
    wr(4, 0);
    pin[0] = 1'b0; step(); pin[0] = 1'b1; step();
    chk("R3 erase pulse with flag", erase, 1);
    rd(7, v);  chk("R6 flag with erase", v, 1);
    step();
    chk("R3 erase pulse ends", erase, 0);
    rd(16, v); chk("R3 bkp0 erased", v, 0);
    rd(23, v); chk("R3 bkp7 erased", v, 0);
  endtask

  task automatic t_int();
    fill_bkp();
    wr(0, 32'h0003_0001);
    wr(5, 32'h8000_0000);
    ievt[0] = 1'b1; step(); ievt[0] = 1'b0;
    rd(7, v);  chk("R5 internal flag set", v & 32'h0003_0000, 32'h0001_0000);
    chk("R3 internal noerase", erase, 0);
    rd(16, v); chk("R3 internal noerase keeps bkp", v, 32'hA0);
    wr(5, 0);
    ievt[1] = 1'b1; step(); ievt[1] = 1'b0;
    chk("R3 internal erase", erase, 1);
    rd(17, v); chk("R3 internal erase bkp", v, 0);
  endtask

  task automatic t_sw();
    fill_bkp();
    wr(9, 1);
    chk("R13 sw erase pulse", erase, 1);
    rd(20, v); chk("R13 sw erase bkp", v, 0);
    fill_bkp();
    pd_rst_n = 1'b0; step(); pd_rst_n = 1'b1; step();
    rd(16, v); chk("R2 power reset clears bkp", v, 0);
  endtask

  initial begin
    rst_n = 0; pd_rst_n = 0; unlock = 0; we = 0; addr = 0; wdata = 0;
    pre_tick = 0; rtc_tick = 0; pin = 3'b000; ievt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; pd_rst_n = 1;
    step();
    t_reset();
    t_lock();
    t_sysreset();
    t_edge();
    t_ts();
    t_level();
    t_irq();
    t_mask();
    t_erase();
    t_int();
    t_sw();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule